// File: doc/BRIEF.md
# Shape-Selectable Two-Clock RAM

This block is a memory of 1,152 bits with one write port and one read port, each with its own clock. A 2-bit shape input decides how the bits are seen as words: 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. The bits always sit in 64 rows of 18 bits. In the narrower shapes the upper address bits choose a row and the lower address bits choose a slice within that row. Narrow words use the low bits of the data buses.

The read side can return data in two ways. In registered mode, the read address is captured on a read clock edge while read enable is high, and the output then follows the stored word at that captured address. In combinational mode, the output follows the live read address and needs no read clock. In both modes, a write to the word being read shows on the output after the write clock edge. A synchronous active-high reset clears the stored bits and the captured read address.

Top module: `ar_dpram`

## Requirements
- R1: After reset is applied, every stored bit reads as zero and the registered read output shows zero.
- R2: The shape input is encoded as 00 for 64x18, 01 for 128x9, 10 for 256x4 and 11 for 512x2.
- R3: Words are arranged in 64 rows of 18 bits. For an N-bit shape with K words per row (K = 1, 2, 4 or 8), the row is address / K (modulo 64) and the slice is bits [(address mod K)*N +: N]. In the x4 and x2 shapes, row bits 16 and 17 are never written.
- R4: A write takes place on the write clock edge only while write enable is high, and it changes only the selected slice of the row.
- R5: Write data bits above the word width of the current shape are ignored.
- R6: Read data bits above the word width of the current shape are zero.
- R7: Address bits above those the current shape needs are ignored on both ports.
- R8: In registered mode, the read address is captured on a read clock edge while read enable is high. While read enable is low, the captured address is held.
- R9: In combinational mode, the read data follows the read address without any read clock edge.
- R10: A write to the word currently being read appears on the read data after the write clock edge, in both read modes.
- R11: Changing the shape does not alter the stored bits. One row can be read back in any shape.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| mode | input | 2 | Shape select (R2 encoding) |
| async_rd | input | 1 | 1 selects combinational read, 0 selects registered read |
| we | input | 1 | Write enable |
| waddr | input | 9 | Write address |
| wdata | input | 18 | Write data, low bits used in narrow shapes |
| re | input | 1 | Read enable, captures the address in registered mode |
| raddr | input | 9 | Read address |
| rdata | output | 18 | Read data, zero above the word width |

## Verification
The bench aims at the slice arithmetic, because a wrong lane shift or mask would corrupt neighbouring words. These faults show up when one row is written in one shape and read back in the other three, and when spare bits 16 and 17 are checked after writes in the x4 and x2 shapes. Garbage in the upper data bits on a write and high address bits beyond the shape are driven on purpose. A design that failed to mask or truncate them would change other slices or rows. Registered reads are checked both for holding while enable is low and for showing a later write to the captured word. A design that cached the data instead of the address would return stale values.

// File: rtl/ar_pkg.sv
package ar_pkg;

    localparam int STORE_BITS = 1152;
    localparam int ROW_W      = 18;
    localparam int ROWS       = STORE_BITS / ROW_W;
    localparam int ROW_AW     = $clog2(ROWS);
    localparam int LANE_W     = 3;
    localparam int ADDR_W     = ROW_AW + LANE_W;
    localparam int DATA_W     = ROW_W;
    localparam int FLAT_W     = ROWS * ROW_W;

    typedef enum logic [1:0] {
        SHAPE_X18 = 2'b00,
        SHAPE_X9  = 2'b01,
        SHAPE_X4  = 2'b10,
        SHAPE_X2  = 2'b11
    } shape_e;

    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic [LANE_W-1:0] lane;
    } loc_t;

    function automatic int unsigned slice_width(shape_e s);
        case (s)
            SHAPE_X18: return 18;
            SHAPE_X9:  return 9;
            SHAPE_X4:  return 4;
            default:   return 2;
        endcase
    endfunction

    function automatic loc_t locate(shape_e s, logic [ADDR_W-1:0] a);
        loc_t l;
        case (s)
            SHAPE_X18: begin
                l.row  = a[ROW_AW-1:0];
                l.lane = '0;
            end
            SHAPE_X9: begin
                l.row  = a[ROW_AW:1];
                l.lane = {{(LANE_W-1){1'b0}}, a[0]};
            end
            SHAPE_X4: begin
                l.row  = a[ROW_AW+1:2];
                l.lane = {1'b0, a[1:0]};
            end
            default: begin
                l.row  = a[ROW_AW+2:3];
                l.lane = a[2:0];
            end
        endcase
        return l;
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(shape_e s);
        logic [DATA_W-1:0] m;
        int unsigned w;
        w = slice_width(s);
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < int'(w));
        end
        return m;
    endfunction

    function automatic int unsigned lane_shift(shape_e s, logic [LANE_W-1:0] lane);
        return int'(lane) * slice_width(s);
    endfunction

endpackage

// File: rtl/ar_addr_map.sv
module ar_addr_map
    import ar_pkg::*;
(
    input  shape_e            shape,
    input  logic [ADDR_W-1:0] addr,
    output loc_t              loc
);
    always_comb begin
        loc = locate(shape, addr);
    end
endmodule

// File: rtl/ar_store.sv
module ar_store
    import ar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  shape_e            shape,
    input  loc_t              loc,
    input  logic [DATA_W-1:0] wdata,
    output logic [FLAT_W-1:0] mem_flat
);
    logic [ROW_W-1:0] rows [ROWS];
    logic [ROW_W-1:0] bit_mask;
    logic [ROW_W-1:0] bit_data;

    always_comb begin
        logic [DATA_W-1:0] wm;
        int unsigned sh;
        wm       = width_mask(shape);
        sh       = lane_shift(shape, loc.lane);
        bit_mask = wm << sh;
        bit_data = (wdata & wm) << sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                rows[r] <= '0;
            end
        end else if (we) begin
            rows[loc.row] <= (rows[loc.row] & ~bit_mask) | (bit_data & bit_mask);
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign mem_flat[g*ROW_W +: ROW_W] = rows[g];
    end
endmodule

// File: rtl/ar_read_fmt.sv
module ar_read_fmt
    import ar_pkg::*;
(
    input  logic [FLAT_W-1:0] mem_flat,
    input  shape_e            shape,
    input  loc_t              loc,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        logic [ROW_W-1:0] row_bits;
        row_bits = mem_flat[int'(loc.row)*ROW_W +: ROW_W];
        rdata    = (row_bits >> lane_shift(shape, loc.lane)) & width_mask(shape);
    end
endmodule

// File: rtl/ar_dpram.sv
module ar_dpram
    import ar_pkg::*;
(
    input  logic        wclk,
    input  logic        rclk,
    input  logic        rst,
    input  logic [1:0]  mode,
    input  logic        async_rd,
    input  logic        we,
    input  logic [8:0]  waddr,
    input  logic [17:0] wdata,
    input  logic        re,
    input  logic [8:0]  raddr,
    output logic [17:0] rdata
);
    shape_e              shape;
    loc_t                wloc;
    loc_t                rloc;
    logic [ROW_AW-1:0]   wrow;
    logic [ADDR_W-1:0]   raddr_q;
    logic [ADDR_W-1:0]   rsel;
    logic [FLAT_W-1:0]   mem_flat;

    assign shape = shape_e'(mode);
    assign wrow  = wloc.row;

    always_ff @(posedge rclk) begin
        if (rst) begin
            raddr_q <= '0;
        end else if (re) begin
            raddr_q <= raddr;
        end
    end

    assign rsel = async_rd ? raddr : raddr_q;

    ar_addr_map u_wmap (
        .shape (shape),
        .addr  (waddr),
        .loc   (wloc)
    );

    ar_addr_map u_rmap (
        .shape (shape),
        .addr  (rsel),
        .loc   (rloc)
    );

    ar_store u_store (
        .clk      (wclk),
        .rst      (rst),
        .we       (we),
        .shape    (shape),
        .loc      (wloc),
        .wdata    (wdata),
        .mem_flat (mem_flat)
    );

    ar_read_fmt u_fmt (
        .mem_flat (mem_flat),
        .shape    (shape),
        .loc      (rloc),
        .rdata    (rdata)
    );
endmodule

// File: rtl/ar_dpram_chk.sv
module ar_dpram_chk
    import ar_pkg::*;
(
    input logic              wclk,
    input logic              rclk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              async_rd,
    input logic              we,
    input logic              re,
    input logic [8:0]        raddr,
    input logic [17:0]       rdata,
    input logic [ADDR_W-1:0] raddr_q,
    input logic [ROW_AW-1:0] wrow,
    input logic [FLAT_W-1:0] mem_flat
);
    logic [17:0] hi_mask;
    always_comb begin
        case (mode)
            2'b00:   hi_mask = 18'h00000;
            2'b01:   hi_mask = 18'h3FE00;
            2'b10:   hi_mask = 18'h3FFF0;
            default: hi_mask = 18'h3FFFC;
        endcase
    end

    // R4: no write enable, no change to stored bits
    a_r4_no_write_hold: assert property (@(posedge wclk) disable iff (rst)
        !we |=> $stable(mem_flat));

    // R3: spare row bits untouched by x4/x2 writes
    a_r3_spare_bits: assert property (@(posedge wclk) disable iff (rst)
        (we && mode[1]) |=> (mem_flat[int'($past(wrow))*ROW_W + 16 +: 2]
                             == $past(mem_flat[int'(wrow)*ROW_W + 16 +: 2])));

    // R6: bits above the word width are zero
    a_r6_upper_zero: assert property (@(posedge rclk) disable iff (rst)
        1'b1 |-> ((rdata & hi_mask) == 18'h0));

    // R8: capture on enable
    a_r8_capture: assert property (@(posedge rclk) disable iff (rst)
        re |=> (raddr_q == $past(raddr)));

    // R8: hold while enable is low
    a_r8_hold: assert property (@(posedge rclk) disable iff (rst)
        !re |=> $stable(raddr_q));
endmodule

bind ar_dpram ar_dpram_chk u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst      (rst),
    .mode     (mode),
    .async_rd (async_rd),
    .we       (we),
    .re       (re),
    .raddr    (raddr),
    .rdata    (rdata),
    .raddr_q  (raddr_q),
    .wrow     (wrow),
    .mem_flat (mem_flat)
);

// File: tb/ar_dpram_bench.sv
module ar_dpram_bench;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst;
    logic [1:0]  mode;
    logic        async_rd;
    logic        we;
    logic [8:0]  waddr;
    logic [17:0] wdata;
    logic        re;
    logic [8:0]  raddr;
    logic [17:0] rdata;

    int checks = 0;
    int fails  = 0;
    logic [17:0] model [64];

    always #5 wclk = ~wclk;
    initial begin
        #2;
        forever #5 rclk = ~rclk;
    end

    ar_dpram u_ar_dpram (
        .wclk(wclk), .rclk(rclk), .rst(rst), .mode(mode), .async_rd(async_rd),
        .we(we), .waddr(waddr), .wdata(wdata), .re(re), .raddr(raddr), .rdata(rdata)
    );

    function automatic int wd(logic [1:0] m);
        case (m)
            2'b00:   return 18;
            2'b01:   return 9;
            2'b10:   return 4;
            default: return 2;
        endcase
    endfunction

    function automatic int per_row(logic [1:0] m);
        case (m)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [17:0] exp_read(logic [1:0] m, logic [8:0] a);
        int r, s;
        logic [17:0] msk;
        r   = (int'(a) / per_row(m)) % 64;
        s   = (int'(a) % per_row(m)) * wd(m);
        msk = 18'((19'd1 << wd(m)) - 19'd1);
        return (model[r] >> s) & msk;
    endfunction

    task automatic model_write(logic [1:0] m, logic [8:0] a, logic [17:0] d);
        int r, s;
        logic [17:0] msk;
        r   = (int'(a) / per_row(m)) % 64;
        s   = (int'(a) % per_row(m)) * wd(m);
        msk = 18'((19'd1 << wd(m)) - 19'd1);
        model[r] = (model[r] & ~(msk << s)) | ((d & msk) << s);
    endtask

    task automatic chk(string tag, logic [17:0] got, logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %05h expected %05h", tag, got, exp);
        end
    endtask

    task automatic do_write(logic [1:0] m, logic [8:0] a, logic [17:0] d);
        @(negedge wclk);
        mode = m; waddr = a; wdata = d; we = 1'b1;
        @(posedge wclk);
        #1 we = 1'b0;
        model_write(m, a, d);
    endtask

    task automatic rd_async(string tag, logic [1:0] m, logic [8:0] a);
        async_rd = 1'b1; mode = m; raddr = a;
        #1 chk(tag, rdata, exp_read(m, a));
    endtask

    task automatic rd_sync(string tag, logic [1:0] m, logic [8:0] a);
        @(negedge rclk);
        async_rd = 1'b0; mode = m; raddr = a; re = 1'b1;
        @(posedge rclk);
        #1 re = 1'b0;
        #1 chk(tag, rdata, exp_read(m, a));
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) model[i] = '0;
        rst = 1'b1; mode = 2'b00; async_rd = 1'b0; we = 1'b0; re = 1'b0;
        waddr = '0; wdata = '0; raddr = '0;
        repeat (5) @(posedge wclk);
        #1 rst = 1'b0;
        #3;
        // R1: reset state
        chk("R1 reset rdata", rdata, 18'h0);
        rd_async("R1 cleared store", 2'b00, 9'd37);

        // R2/R3: one row seen through every shape (R11 mode change keeps data)
        do_write(2'b00, 9'd3, 18'h2A5C3);
        rd_async("R11 x18 view", 2'b00, 9'd3);
        rd_async("R11 x9 low", 2'b01, 9'd6);
        rd_async("R11 x9 high", 2'b01, 9'd7);
        for (int k = 0; k < 4; k++) rd_async("R2 x4 lane", 2'b10, 9'(12 + k));
        for (int k = 0; k < 8; k++) rd_async("R2 x2 lane", 2'b11, 9'(24 + k));

        // R3: spare bits kept by x4 writes
        do_write(2'b00, 9'd10, 18'h3FFFF);
        for (int k = 0; k < 4; k++) do_write(2'b10, 9'(40 + k), 18'h0);
        async_rd = 1'b1; mode = 2'b00; raddr = 9'd10;
        #1 chk("R3 spare bits", rdata, 18'h30000);

        // R5: high write bits ignored, neighbours intact
        do_write(2'b00, 9'd20, 18'h12345);
        do_write(2'b10, 9'd81, 18'h3FFF5);
        rd_async("R5 slice written", 2'b10, 9'd81);
        rd_async("R5 neighbour row", 2'b00, 9'd20);
        // R6: upper read bits zero
        async_rd = 1'b1; mode = 2'b11; raddr = 9'd161;
        #1 chk("R6 upper zero", rdata & 18'h3FFFC, 18'h0);

        // R7: unused high address bits ignored
        do_write(2'b00, 9'h1C5, 18'h0BEEF);
        rd_async("R7 alias x18", 2'b00, 9'h005);
        rd_async("R7 alias read", 2'b00, 9'h145);

        // R4: write enable low leaves store unchanged
        @(negedge wclk);
        mode = 2'b00; waddr = 9'd5; wdata = 18'h11111; we = 1'b0;
        @(posedge wclk);
        #1 rd_async("R4 no write", 2'b00, 9'd5);

        // R8: capture and hold
        rd_sync("R8 capture", 2'b00, 9'd3);
        @(negedge rclk);
        raddr = 9'd20; re = 1'b0;
        repeat (2) @(posedge rclk);
        #1 chk("R8 hold", rdata, model[3]);

        // R10: write-through in registered mode
        do_write(2'b00, 9'd3, 18'h01F0F);
        #1 chk("R10 sync through", rdata, 18'h01F0F);
        // R9/R10: combinational follow and write-through
        rd_async("R9 async follow", 2'b01, 9'd41);
        do_write(2'b01, 9'd41, 18'h1A5);
        #1 chk("R10 async through", rdata, 18'h1A5);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  m;
            logic [8:0]  a;
            logic [17:0] d;
            int op;
            m  = 2'($urandom);
            a  = 9'($urandom);
            d  = 18'($urandom);
            op = int'($urandom % 3);
            if (op == 0) do_write(m, a, d);
            else if (op == 1) rd_async("R9 random async", m, a);
            else rd_sync("R8 random sync", m, a);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule